// File: doc/BRIEF.md
# Early-End Transfer Record Queue

This block keeps a short queue of records for transfers that finished before their programmed length, such as a streaming source ending a packet early. Each record holds the transfer identifier and the count of bytes that were actually moved. A record is kept only when the transfer asked for this kind of report. Every completion that reaches the block also marks that identifier as done and raises a one-cycle end-of-transfer pulse, whether or not a record was kept.

Software empties the queue through a read-only register window. It reads the length of the head record first and then its identifier. Reading the identifier removes the head record. Bit 31 of the completion register stays at 1 while any record is waiting, so software repeats the pair of reads until that bit reads 0.

The record input is a valid/ready stream, but the datapath cannot be stalled. `rec_ready` is low only when the queue is full and no pop happens in the same cycle. A record offered while `rec_ready` is low is dropped and latches the overflow flag.

Top module: `prt_report`

## Requirements
- R1: After reset, `rec_ready` is 1, `eot_irq` is 0, and every register reads 0.
- R2: An accepted record with `rec_report`=1 is queued. The completion register (`rd_sel`=0) reads bit 31 as 1 while at least one record is queued.
- R3: A completion with `rec_report`=0 queues no record, but it still sets its done bit and still pulses `eot_irq`.
- R4: The length register (`rd_sel`=1) returns the head record's byte count, zero-extended. Reading it has no side effect, so repeated reads return the same value.
- R5: The identifier register (`rd_sel`=2) returns the head identifier in bits [ID_W-1:0] and pops that record. Records come out in arrival order.
- R6: The queue holds DEPTH records. A record offered when the queue is full and no pop happens in that cycle is dropped, with `rec_ready` low. The drop sets bit 0 of the status register (`rd_sel`=3), and that bit stays set until reset.
- R7: When the queue is full and the identifier register is read in the same cycle as a record is offered, `rec_ready` is 1 and the new record is queued behind the remaining ones.
- R8: Every completion with an identifier below NUM_IDS sets bit `rec_id` of the completion register. Reading the completion register clears those bits. A completion in the same cycle as that read sets its bit after the clear, and the read returns the state from before that cycle.
- R9: `eot_irq` is high for exactly the cycle after each cycle in which `rec_valid` is 1.
- R10: Reading the length or identifier register while the queue is empty returns 0 and changes nothing.
- R11: `rd_data` carries the value selected in the cycle after `rd_en`, and is 0 in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | A transfer completion is offered this cycle |
| rec_ready | output | 1 | Queue can accept a record this cycle |
| rec_report | input | 1 | Completion asked for an early-end record |
| rec_id | input | ID_W | Identifier of the completing transfer |
| rec_len | input | LEN_W | Bytes actually moved |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | 0 completion, 1 length, 2 identifier, 3 status |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| eot_irq | output | 1 | End-of-transfer pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first is a pop by an identifier read together with a new record arriving on a full queue. The second is a clear of the completion register together with a new done bit being set. The bench drives both of these in a single cycle. A scoreboard model applies the read first, then the pop or clear, then the push. The bench then judges the read value, `rec_ready`, and the contents later drained from the queue against that model.

// File: rtl/prt_pkg.sv
`timescale 1ns/1ps
package prt_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PEND_BIT = 31;

  typedef enum logic [1:0] {
    SEL_DONE = 2'd0,
    SEL_PLEN = 2'd1,
    SEL_PID  = 2'd2,
    SEL_STAT = 2'd3
  } prt_sel_e;
endpackage

// File: rtl/prt_fifo.sv
`timescale 1ns/1ps
module prt_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               slot[g] <= '0;
      else if (push && wr_ptr == PTR_W'(g))     slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = slot[rd_ptr];
  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));
  a_r5_pop_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (level == $past(level) - 1'b1));
  a_r2_push_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/prt_done.sv
`timescale 1ns/1ps
module prt_done #(
  parameter int unsigned NUM_IDS = 8,
  parameter int unsigned ID_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [ID_W-1:0]    set_id,
  input  logic               clr,
  output logic [NUM_IDS-1:0] done_q,
  output logic               irq
);
  logic [NUM_IDS-1:0] hit;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_bit
    assign hit[g] = set_en && (set_id == ID_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) done_q[g] <= 1'b0;
      else        done_q[g] <= hit[g] | (done_q[g] & ~clr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= set_en;
  end

  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && int'(set_id) < NUM_IDS) |=> done_q[$past(set_id)]);
  a_r8_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_en) |=> (done_q == '0));
endmodule

// File: rtl/prt_report.sv
`timescale 1ns/1ps
module prt_report
  import prt_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned ID_W    = 5,
  parameter int unsigned LEN_W   = 24,
  parameter int unsigned NUM_IDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic             rec_report,
  input  logic [ID_W-1:0]  rec_id,
  input  logic [LEN_W-1:0] rec_len,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic             eot_irq
);
  localparam int unsigned W = ID_W + LEN_W;

  logic               full, empty, pop, push, drop, ovf_q;
  logic [W-1:0]       head;
  logic [ID_W-1:0]    head_id;
  logic [LEN_W-1:0]   head_len;
  logic [NUM_IDS-1:0] done_q;
  logic               rd_done;
  logic [REG_W-1:0]   rd_mux;

  assign pop       = rd_en && (prt_sel_e'(rd_sel) == SEL_PID) && !empty;
  assign rd_done   = rd_en && (prt_sel_e'(rd_sel) == SEL_DONE);
  assign rec_ready = !full || pop;
  assign push      = rec_valid && rec_report && rec_ready;
  assign drop      = rec_valid && rec_report && !rec_ready;

  prt_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata ({rec_id, rec_len}),
    .rdata (head),
    .full  (full),
    .empty (empty)
  );

  prt_done #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_done (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (rec_valid),
    .set_id (rec_id),
    .clr    (rd_done),
    .done_q (done_q),
    .irq    (eot_irq)
  );

  assign head_id  = head[W-1 -: ID_W];
  assign head_len = head[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    unique case (prt_sel_e'(rd_sel))
      SEL_DONE: begin
        rd_mux[NUM_IDS-1:0] = done_q;
        rd_mux[PEND_BIT]    = !empty;
      end
      SEL_PLEN: if (!empty) rd_mux[LEN_W-1:0] = head_len;
      SEL_PID:  if (!empty) rd_mux[ID_W-1:0]  = head_id;
      SEL_STAT: rd_mux[0] = ovf_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_mux : '0;
  end

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> eot_irq);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> !eot_irq);
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_report && !rec_ready) |=> ovf_q);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
  a_r10_empty_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1 && empty) |=> (rd_data == '0));
endmodule

// File: tb/test_prt_report.sv
`timescale 1ns/1ps
module test_prt_report;
  localparam int DEPTH = 4, ID_W = 5, LEN_W = 24, NUM_IDS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_valid = 0, rec_report = 0, rd_en = 0;
  logic [ID_W-1:0]  rec_id = '0;
  logic [LEN_W-1:0] rec_len = '0;
  logic [1:0]  rd_sel = '0;
  logic        rec_ready, eot_irq;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [ID_W-1:0] id; logic [LEN_W-1:0] len; } rec_t;
  rec_t sb[$];
  logic [NUM_IDS-1:0] exp_done = '0;
  logic exp_ovf = 0;

  always #2 clk = ~clk;

  prt_report #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W), .NUM_IDS(NUM_IDS)) i_prt_report (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_report(rec_report), .rec_id(rec_id), .rec_len(rec_len),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .eot_irq(eot_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] sel);
    logic [31:0] v = '0;
    case (sel)
      2'd0: begin v[NUM_IDS-1:0] = exp_done; v[31] = (sb.size() != 0); end
      2'd1: if (sb.size() != 0) v = 32'(sb[0].len);
      2'd2: if (sb.size() != 0) v = 32'(sb[0].id);
      default: v[0] = exp_ovf;
    endcase
    return v;
  endfunction

  // One cycle of stimulus; the model applies read, then pop/clear, then push.
  task automatic cycle(input bit pv, input bit rep, input int id, input int len,
                       input bit rv, input logic [1:0] sel, input string rtag,
                       input string ytag);
    logic [31:0] exp_rd;
    bit exp_rdy, popping;
    rec_t r;
    @(negedge clk);
    rec_valid = pv; rec_report = rep; rec_id = ID_W'(id); rec_len = LEN_W'(len);
    rd_en = rv; rd_sel = sel;
    exp_rd  = rv ? model_read(sel) : 32'd0;
    popping = rv && sel == 2'd2 && sb.size() != 0;
    exp_rdy = (sb.size() < DEPTH) || popping;
    #1;
    if (pv && rep) chk(ytag, 32'(rec_ready), 32'(exp_rdy));
    if (popping) void'(sb.pop_front());
    if (rv && sel == 2'd0) exp_done = '0;
    if (pv) begin
      if (id < NUM_IDS) exp_done[id] = 1'b1;
      if (rep) begin
        if (exp_rdy) begin r.id = ID_W'(id); r.len = LEN_W'(len); sb.push_back(r); end
        else exp_ovf = 1'b1;
      end
    end
    @(negedge clk);
    rec_valid = 0; rec_report = 0; rd_en = 0;
    chk(rv ? rtag : "R11", rd_data, exp_rd);
    chk("R9", 32'(eot_irq), 32'(pv));
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    cycle(0, 0, 0, 0, 1, sel, tag, "");
  endtask

  task automatic drain();
    while (sb.size() != 0) begin
      rd(2'd1, "R4");
      rd(2'd1, "R4");
      rd(2'd2, "R5");
    end
    rd(2'd0, "R2");
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", 32'(rec_ready), 32'd1);
    chk("R1", 32'(eot_irq), 32'd0);
    rd(2'd0, "R1"); rd(2'd3, "R1");
    // R10 empty reads
    rd(2'd1, "R10"); rd(2'd2, "R10"); rd(2'd0, "R10");
    // R3 completion without report
    cycle(1, 0, 3, 100, 0, 2'd0, "", "R3");
    rd(2'd0, "R3");
    rd(2'd0, "R8");
    // R2 queued records, pending bit
    cycle(1, 1, 1, 10, 0, 2'd0, "", "R2");
    cycle(1, 1, 2, 20, 0, 2'd0, "", "R2");
    cycle(1, 1, 5, 24'h123456, 0, 2'd0, "", "R2");
    rd(2'd0, "R2");
    drain();
    // R6 fill and overflow
    cycle(1, 1, 6, 60, 0, 2'd0, "", "R6");
    cycle(1, 1, 7, 70, 0, 2'd0, "", "R6");
    cycle(1, 1, 0, 5, 0, 2'd0, "", "R6");
    cycle(1, 1, 4, 40, 0, 2'd0, "", "R6");
    cycle(1, 1, 2, 77, 0, 2'd0, "", "R6");
    rd(2'd3, "R6");
    drain();
    rd(2'd3, "R6");
    // R7 push with pop on a full queue
    for (int k = 0; k < DEPTH; k++) cycle(1, 1, 10 + k, 100 + k, 0, 2'd0, "", "R7");
    cycle(1, 1, 20, 999, 1, 2'd2, "R7", "R7");
    drain();
    // R8 done set and clear in the same cycle
    rd(2'd0, "R8");
    cycle(1, 0, 4, 1, 1, 2'd0, "R8", "R8");
    rd(2'd0, "R8");
    // R10 empty read does not disturb later records
    rd(2'd2, "R10");
    cycle(1, 1, 31, 8, 0, 2'd0, "", "R10");
    drain();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule